// File: doc/BRIEF.md
# Write-Only Control Register Slave on a Two-Wire Bus

This block is a receive-only slave on a two-wire serial control bus (I2C). It owns three control registers: a sample-rate byte, a 16-bit volume word and a global configuration byte. A bus master writes them with a fixed device byte, then a subaddress byte, then one or two data bytes. The subaddress carries a register address and a 2-bit chip-select field. The block answers only when that field equals the value on its two strap inputs. Up to four such slaves can therefore sit behind the same bus address.

SCL and SDA are sampled with a synchronizer on the system clock. Acknowledges are driven through an open-drain enable: while `sda_oe` is high, the pad pulls SDA low. A mode input forces the chip-select value to 3 regardless of the straps. Reset clears every register. The cycle after reset is released, a one-shot step loads the defaults into the volume and configuration registers.

Top module: `ctl_regs_i2c_wr`

## Requirements
- R1: The device byte 0x9A (seven address bits plus a write bit of 0) is acknowledged. Any other device byte is not acknowledged, including 0x9B (a read request). After a NACK the slave stays silent: it drives no acknowledge and writes nothing until the next START.
- R2: `sda_oe` rises only on an SCL falling edge that follows the eighth data bit of an accepted byte. It falls on the next SCL falling edge, or on a START or STOP. During data bits it stays low.
- R3: The subaddress byte is accepted only when all three of these hold: bits [7:4] are zero, bits [3:2] equal the effective chip select, and bits [1:0] (the register address) are nonzero. Otherwise it is not acknowledged.
- R4: The effective chip select is `strap_cs` while `fixed_cs_mode` is low, and 3 while it is high.
- R5: Register address 1 (sample rate) and address 3 (configuration) are 8 bits wide. Each is loaded from the first data byte at that byte's acknowledge. A second data byte is not acknowledged.
- R6: Register address 2 (volume) is 16 bits wide. The high byte comes first. The word is committed only when the second data byte is acknowledged. A STOP or START after one data byte leaves the register unchanged.
- R7: While `rst_n` is low at a clock edge, all three registers read zero.
- R8: One clock after `rst_n` is released, the defaults are in place: volume 16'h2C2C, configuration 8'h04. The sample-rate register stays 0.
- R9: A register changes only through a committed write to its address or through the default load. Rejected transactions leave all registers as they were.
- R10: A repeated START at any point ends the current transaction without committing a pending volume high byte. The slave then restarts at the device byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (acknowledge) |
| strap_cs | input | 2 | Chip-select straps |
| fixed_cs_mode | input | 1 | High forces the chip select to 3 |
| rate_reg | output | 8 | Sample-rate register |
| vol_reg | output | 16 | Volume register |
| cfg_reg | output | 8 | Global configuration register |

## Verification
The bench targets the following corner cases:

- **Subaddress rejection.** A subaddress that is rejected for any single reason must not be acknowledged: wrong chip select, a nonzero upper nibble, or register address 0. A slave that decoded only the low bits would acknowledge it, and a later data byte would corrupt a register.
- **Forced chip select.** With the mode input high, the strap value must be ignored. A design that skips this answers at the wrong select.
- **Width by address.** An 8-bit register must NACK its second data byte, and volume must need both bytes. A design that commits on the first volume byte changes volume after a write that was aborted by STOP or by a repeated START.
- **Reset sequencing.** Reset must show zeros first and only then the defaults, and must leave the sample-rate register at zero. A design that loaded defaults during reset, or into every register, fails these checks.

// File: rtl/ctl_i2c_pkg.sv
// Package: shared types and register addresses for the control-register slave.
// Assumes: two-bit register addresses; address 0 holds no register.
package ctl_i2c_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // waiting for START
        PH_RX   = 2'd1,   // shifting in a byte
        PH_ACK  = 2'd2,   // driving the acknowledge bit
        PH_MUTE = 2'd3    // rejected, silent until next START
    } phase_t;

    localparam logic [1:0] RA_RATE = 2'd1;
    localparam logic [1:0] RA_VOL  = 2'd2;
    localparam logic [1:0] RA_CFG  = 2'd3;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: synchronizes SCL/SDA into the clk domain and flags edges and bus
// conditions. Assumes SCL/SDA are slow compared to clk (several clk periods per
// level). Lines reset to the idle-high state.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    // Shift the raw lines through the synchronizer chain.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Decode edges and START/STOP (SDA moving while SCL stays high).
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2c_wr_engine.sv
// Module: write-only transaction engine. It shifts in bytes, decides the
// acknowledge for each, decodes the subaddress and emits one-cycle commit pulses.
// Assumes: edge strobes are one cycle wide; the volume register is the only
// 16-bit one.
module i2c_wr_engine
    import ctl_i2c_pkg::*;
#(
    parameter logic [7:0] DEV_BYTE = 8'h9A,
    parameter logic [1:0] FIXED_CS = 2'd3,
    parameter int         DW       = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [1:0]    strap_cs,
    input  logic          fixed_cs_mode,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [1:0]    wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int BW = DW / 2;

    phase_t        phase;
    logic [BW-1:0] shreg;
    logic [3:0]    bit_cnt;
    logic [2:0]    byte_idx;
    logic [BW-1:0] hi_byte;
    logic [1:0]    eff_cs;
    logic          is_wide;
    logic          take;

    // Pick the chip-select value and judge whether the byte just received is accepted.
    always_comb begin
        eff_cs  = fixed_cs_mode ? FIXED_CS : strap_cs;
        is_wide = (wr_addr == RA_VOL);
        case (byte_idx)
            3'd0:    take = (shreg == DEV_BYTE);
            3'd1:    take = (shreg[7:4] == 4'd0) && (shreg[3:2] == eff_cs) &&
                            (shreg[1:0] != 2'd0);
            3'd2:    take = 1'b1;
            3'd3:    take = is_wide;
            default: take = 1'b0;
        endcase
    end

    // Transaction state machine: receive, acknowledge, commit or go silent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            shreg    <= '0;
            bit_cnt  <= '0;
            byte_idx <= '0;
            hi_byte  <= '0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                phase    <= PH_RX;
                bit_cnt  <= '0;
                byte_idx <= '0;
                sda_oe   <= 1'b0;
            end else if (stop_det) begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (phase)
                    PH_RX: begin
                        if (scl_rise && bit_cnt < 4'd8) begin
                            shreg   <= {shreg[BW-2:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (scl_fall && bit_cnt == 4'd8) begin
                            if (take) begin
                                sda_oe <= 1'b1;
                                phase  <= PH_ACK;
                                if (byte_idx == 3'd1) begin
                                    wr_addr <= shreg[1:0];
                                end
                                if (byte_idx == 3'd2) begin
                                    if (is_wide) begin
                                        hi_byte <= shreg;
                                    end else begin
                                        wr_en   <= 1'b1;
                                        wr_data <= {{BW{1'b0}}, shreg};
                                    end
                                end
                                if (byte_idx == 3'd3) begin
                                    wr_en   <= 1'b1;
                                    wr_data <= {hi_byte, shreg};
                                end
                            end else begin
                                phase <= PH_MUTE;
                            end
                        end
                    end
                    PH_ACK: begin
                        if (scl_fall) begin
                            sda_oe   <= 1'b0;
                            bit_cnt  <= '0;
                            byte_idx <= byte_idx + 3'd1;
                            phase    <= PH_RX;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/ctl_reg_bank.sv
// Module: the three control registers. Reset clears them; one clock after reset
// is released, the defaults are loaded once. Assumes one-cycle write pulses.
module ctl_reg_bank
    import ctl_i2c_pkg::*;
#(
    parameter int            DW          = 16,
    parameter logic [DW-1:0] VOL_DEFAULT = 16'h2C2C,
    parameter logic [7:0]    CFG_DEFAULT = 8'h04
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [7:0]    rate_q,
    output logic [DW-1:0] vol_q,
    output logic [7:0]    cfg_q,
    output logic          dflt_load
);
    logic init_pend;

    assign dflt_load = init_pend;

    // Arm the one-shot default load during reset; clear it once used.
    always_ff @(posedge clk) begin
        if (!rst_n) init_pend <= 1'b1;
        else        init_pend <= 1'b0;
    end

    // Register update: clear, default load, then committed writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '0;
            vol_q  <= '0;
            cfg_q  <= '0;
        end else if (init_pend) begin
            vol_q <= VOL_DEFAULT;
            cfg_q <= CFG_DEFAULT;
        end else if (wr_en) begin
            case (wr_addr)
                RA_RATE: rate_q <= wr_data[7:0];
                RA_VOL:  vol_q  <= wr_data;
                RA_CFG:  cfg_q  <= wr_data[7:0];
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/ctl_regs_i2c_wr.sv
// Module: top of the write-only control-register slave. Connects the line
// synchronizer, the transaction engine and the register bank.
// Assumes: the pad turns sda_oe into an open-drain pull-down on SDA.
module ctl_regs_i2c_wr #(
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  DEV_BYTE    = 8'h9A,
    parameter logic [15:0] VOL_DEFAULT = 16'h2C2C,
    parameter logic [7:0]  CFG_DEFAULT = 8'h04
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [1:0]  strap_cs,
    input  logic        fixed_cs_mode,
    output logic [7:0]  rate_reg,
    output logic [15:0] vol_reg,
    output logic [7:0]  cfg_reg
);
    localparam int DW = 16;

    logic          sda_s;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_det;
    logic          stop_det;
    logic          wr_en;
    logic [1:0]    wr_addr;
    logic [DW-1:0] wr_data;
    logic          dflt_load;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_wr_engine #(.DEV_BYTE(DEV_BYTE), .FIXED_CS(2'd3), .DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .strap_cs(strap_cs), .fixed_cs_mode(fixed_cs_mode), .sda_oe(sda_oe),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    ctl_reg_bank #(.DW(DW), .VOL_DEFAULT(VOL_DEFAULT), .CFG_DEFAULT(CFG_DEFAULT)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rate_q(rate_reg), .vol_q(vol_reg), .cfg_q(cfg_reg),
        .dflt_load(dflt_load)
    );
endmodule

// File: rtl/ctl_regs_i2c_wr_chk.sv
// Module: assertion checker bound to ctl_regs_i2c_wr. It relates acknowledge
// timing to bus edges, and register changes to commit pulses.
module ctl_regs_i2c_wr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_fall,
    input logic        start_det,
    input logic        stop_det,
    input logic        sda_oe,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic        dflt_load,
    input logic [7:0]  rate_reg,
    input logic [15:0] vol_reg,
    input logic [7:0]  cfg_reg
);
    assert_ack_rise_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    assert_ack_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> $past(scl_fall || start_det || stop_det));

    assert_start_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    assert_commit_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    assert_no_addr0_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr != 2'd0));

    assert_rate_only_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rate_reg) |-> $past(wr_en && wr_addr == 2'd1));

    assert_vol_only_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vol_reg) |-> $past(dflt_load || (wr_en && wr_addr == 2'd2)));

    assert_cfg_only_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_reg) |-> $past(dflt_load || (wr_en && wr_addr == 2'd3)));
endmodule

bind ctl_regs_i2c_wr ctl_regs_i2c_wr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr),
    .dflt_load(dflt_load), .rate_reg(rate_reg), .vol_reg(vol_reg), .cfg_reg(cfg_reg)
);

// File: tb/ctl_regs_i2c_wr_tb.sv
module ctl_regs_i2c_wr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [1:0]  strap_cs = 2'd0;
    logic        fixed_cs_mode = 1'b0;
    logic [7:0]  rate_reg;
    logic [15:0] vol_reg;
    logic [7:0]  cfg_reg;
    logic        sda_bus;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_regs_i2c_wr u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .strap_cs(strap_cs), .fixed_cs_mode(fixed_cs_mode),
        .rate_reg(rate_reg), .vol_reg(vol_reg), .cfg_reg(cfg_reg)
    );

    // Vector: fixed, strap, sub, d1, d2, ack_sub, ack_d1, ack_d2, rate, vol, cfg after.
    localparam logic [61:0] VEC [0:9] = '{
        {1'b0, 2'd0, 8'h01, 8'h55, 8'hAA, 3'b110, 8'h55, 16'h2C2C, 8'h04}, // R5 rate
        {1'b0, 2'd0, 8'h02, 8'h12, 8'h34, 3'b111, 8'h55, 16'h1234, 8'h04}, // R6 vol
        {1'b0, 2'd0, 8'h03, 8'h81, 8'h00, 3'b110, 8'h55, 16'h1234, 8'h81}, // R5 cfg
        {1'b0, 2'd2, 8'h0A, 8'h3C, 8'h5A, 3'b111, 8'h55, 16'h3C5A, 8'h81}, // R3 cs=2
        {1'b0, 2'd2, 8'h02, 8'h77, 8'h77, 3'b000, 8'h55, 16'h3C5A, 8'h81}, // R3 mismatch
        {1'b1, 2'd0, 8'h0D, 8'h66, 8'h00, 3'b110, 8'h66, 16'h3C5A, 8'h81}, // R4 forced 3
        {1'b1, 2'd0, 8'h01, 8'h99, 8'h00, 3'b000, 8'h66, 16'h3C5A, 8'h81}, // R4 strap ignored
        {1'b0, 2'd1, 8'h15, 8'h11, 8'h00, 3'b000, 8'h66, 16'h3C5A, 8'h81}, // R3 upper nibble
        {1'b0, 2'd1, 8'h04, 8'h11, 8'h00, 3'b000, 8'h66, 16'h3C5A, 8'h81}, // R3 addr 0
        {1'b0, 2'd3, 8'h0F, 8'hC3, 8'h00, 3'b110, 8'h66, 16'h3C5A, 8'hC3}  // R5 cfg cs=3
    };

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; w(Q);
        sda_m = 1'b0; w(Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b0; w(Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b1; w(2*Q);
    endtask

    // Send one byte MSB first, return the acknowledge, check the R2 drive window.
    task automatic bus_byte(input logic [7:0] b, output logic ack);
        logic oe_seen;
        oe_seen = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; w(Q);
            scl_m = 1'b1; w(Q);
            oe_seen = oe_seen | sda_oe;
            w(Q);
            scl_m = 1'b0; w(Q);
        end
        check("R2 no drive during data bits", {31'd0, oe_seen}, 32'd0);
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(Q);
        ack = ~sda_bus;
        w(Q);
        scl_m = 1'b0; w(Q);
        if (ack) check("R2 released after ninth clock", {31'd0, sda_oe}, 32'd0);
    endtask

    task automatic do_reset(input int n);
        @(negedge clk); rst_n = 1'b0;
        w(n);
        check("R7 rate zero in reset", {24'd0, rate_reg}, 32'd0);
        check("R7 vol zero in reset", {16'd0, vol_reg}, 32'd0);
        check("R7 cfg zero in reset", {24'd0, cfg_reg}, 32'd0);
        rst_n = 1'b1;
        w(1);
        check("R8 vol default", {16'd0, vol_reg}, 32'h2C2C);
        check("R8 cfg default", {24'd0, cfg_reg}, 32'h04);
        check("R8 rate not loaded", {24'd0, rate_reg}, 32'd0);
        w(4);
    endtask

    initial begin
        logic a0, a1, a2, a3;
        do_reset(5);

        // Table walk: one transaction per entry.
        for (int k = 0; k < 10; k++) begin
            fixed_cs_mode = VEC[k][61];
            strap_cs      = VEC[k][60:59];
            w(4);
            bus_start();
            bus_byte(8'h9A, a0);
            bus_byte(VEC[k][58:51], a1);
            bus_byte(VEC[k][50:43], a2);
            bus_byte(VEC[k][42:35], a3);
            bus_stop();
            check($sformatf("R1 dev ack vec%0d", k), {31'd0, a0}, 32'd1);
            check($sformatf("R3 R4 sub ack vec%0d", k), {31'd0, a1}, {31'd0, VEC[k][34]});
            check($sformatf("R5 R6 d1 ack vec%0d", k), {31'd0, a2}, {31'd0, VEC[k][33]});
            check($sformatf("R5 R6 d2 ack vec%0d", k), {31'd0, a3}, {31'd0, VEC[k][32]});
            check($sformatf("R9 rate vec%0d", k), {24'd0, rate_reg}, {24'd0, VEC[k][31:24]});
            check($sformatf("R9 vol vec%0d", k), {16'd0, vol_reg}, {16'd0, VEC[k][23:8]});
            check($sformatf("R9 cfg vec%0d", k), {24'd0, cfg_reg}, {24'd0, VEC[k][7:0]});
        end
        fixed_cs_mode = 1'b0;
        strap_cs = 2'd0;
        w(4);

        // R1: read request NACKed, then silent.
        bus_start();
        bus_byte(8'h9B, a0);
        bus_byte(8'h01, a1);
        bus_byte(8'h12, a2);
        bus_stop();
        check("R1 read byte nack", {31'd0, a0}, 32'd0);
        check("R1 silent after nack", {30'd0, a1, a2}, 32'd0);
        check("R1 rate untouched", {24'd0, rate_reg}, 32'h66);

        // R1: foreign address.
        bus_start();
        bus_byte(8'h34, a0);
        bus_stop();
        check("R1 foreign address nack", {31'd0, a0}, 32'd0);

        // R6: STOP after the volume high byte.
        bus_start();
        bus_byte(8'h9A, a0);
        bus_byte(8'h02, a1);
        bus_byte(8'hEE, a2);
        bus_stop();
        check("R6 high byte acked", {30'd0, a1, a2}, 32'd3);
        check("R6 vol unchanged after stop", {16'd0, vol_reg}, 32'h3C5A);

        // R10: repeated START after the volume high byte, then a rate write.
        bus_start();
        bus_byte(8'h9A, a0);
        bus_byte(8'h02, a1);
        bus_byte(8'h11, a2);
        bus_rstart();
        bus_byte(8'h9A, a0);
        bus_byte(8'h01, a1);
        bus_byte(8'h22, a2);
        bus_stop();
        check("R10 restart acks", {29'd0, a0, a1, a2}, 32'd7);
        check("R10 vol not committed", {16'd0, vol_reg}, 32'h3C5A);
        check("R10 rate written", {24'd0, rate_reg}, 32'h22);

        // R10: repeated START wakes a silenced slave.
        bus_start();
        bus_byte(8'h9A, a0);
        bus_byte(8'h15, a1);
        bus_rstart();
        bus_byte(8'h9A, a0);
        bus_byte(8'h03, a2);
        bus_byte(8'h5E, a3);
        bus_stop();
        check("R10 rejected sub nack", {31'd0, a1}, 32'd0);
        check("R10 acks after restart", {29'd0, a0, a2, a3}, 32'd7);
        check("R10 cfg written", {24'd0, cfg_reg}, 32'h5E);

        // R7 R8: reset in the middle of operation.
        do_reset(3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule